// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block walks one root port from reset to a trained link without software in the loop. A single start strobe launches the sequence. The sequencer first checks whether the link already reports up, and if so it finishes at once. Otherwise it enables the application clock and holds the downstream device in reset (PERST#, active low). It can optionally switch on slot power. It then runs a request/acknowledge handshake for each of the two reference clocks, enables the lane clocks and then the port clock, and keeps PERST# asserted for a guard time. That guard time is longer when power was switched on in this run. After that it releases reset, waits for the port to report ready, releases the clock-gate overrides, fires a single training start pulse, and waits for link-up. A final settle delay must pass before the block signals that configuration traffic may go downstream.

All waits come from a free-running microsecond tick made by dividing the core clock. Every polling loop is bounded. A missing clock acknowledge is recorded but does not stop the sequence. A missing ready or link-up ends the run with a failure code that names the phase.

Top module: `pcie_port_bringup`

## Requirements
- R1: After reset the sequencer is idle with `perst_n_o` low and every other output low, including `busy_o`, `done_o`, `ok_o` and `status_o`.
- R2: A start seen while `link_up_i` is high changes no drive output. It sets `done_o`=1, `ok_o`=1 and `status_o`=0 on the next clock, and `busy_o` stays low.
- R3: An accepted start enables the application clock and holds `perst_n_o` low. `pwr_en_o` follows `pwr_opt_i` as sampled at the start of the run.
- R4: Request bit 0 is raised first. Request bit 1 is raised only after acknowledge bit 0 has been seen, or after ACK_POLLS failed samples spaced POLL_US apart. A missing acknowledge does not stop the run.
- R5: Once both acknowledge waits end, both lane clock enables rise in the same cycle. The port clock enable rises one cycle later.
- R6: `perst_n_o` rises no earlier than PERST_SHORT_US after the port clock enable. When power was driven in this run, that minimum is PERST_LONG_US instead.
- R7: After PERST# release, `port_ready_i` is sampled up to READY_POLLS times, POLL_US apart. If it never appears, the run ends with status 2, `ok_o`=0, no training pulse and the gate-override clear left low.
- R8: When ready is seen, `gate_dis_clr_o` goes high and `ltssm_start_o` pulses for exactly one cycle.
- R9: After the training pulse, `link_up_i` is sampled up to LINK_POLLS times, POLL_US apart. If it never appears, the run ends with status 3 and `ok_o`=0.
- R10: After link-up is seen, `done_o` rises with `ok_o`=1 no earlier than SETTLE_US later.
- R11: A start strobe that arrives while `busy_o` is high has no effect. The run is neither restarted nor shortened.
- R12: Status codes are 0 (clean success), 1 (success, but a clock acknowledge timed out), 2 (ready timeout) and 3 (link-up timeout). A ready or link failure takes priority over code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| pwr_opt_i | input | 1 | Drive slot power during this run |
| refclk_ack_i | input | 2 | Reference clock acknowledges, bit 0 and bit 1 |
| port_ready_i | input | 1 | Port reports ready after reset release |
| link_up_i | input | 1 | Link training complete |
| app_clk_en_o | output | 1 | Application clock enable |
| perst_n_o | output | 1 | Downstream reset, low = asserted |
| pwr_en_o | output | 1 | Slot power enable |
| refclk_req_o | output | 2 | Reference clock requests |
| refclk_lane_en_o | output | 2 | Lane reference clock enables |
| port_refclk_en_o | output | 1 | Port reference clock enable |
| gate_dis_clr_o | output | 1 | Clears the clock-gate-disable overrides |
| ltssm_start_o | output | 1 | One-cycle link training start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Run finished; held until the next accepted start |
| ok_o | output | 1 | Link came up (valid with done) |
| status_o | output | 2 | Outcome code (valid with done) |

## Verification
The microsecond tick runs freely, so a delay of L microseconds lasts between (L-1) and L tick periods, plus one cycle for the registered expiry and one for the registered output. The bench therefore checks each guard time (PERST# hold, settle, poll timeouts) against a window computed from those terms. It records the exact cycle of every output edge at the falling clock edge and compares the differences. Pure ordering results are due on exact cycles: both lane enables rise together, the port clock enable rises exactly one cycle after them, and the skip path sets done one cycle after the start. The bench compares these to exact counts. It sweeps every combination of prompt, late and missing acknowledges, present or missing ready and link, and both power settings, on a shortened timing configuration.

// File: rtl/pbu_pkg.sv
// Shared types for the port bring-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pbu_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREP,
        S_REQ0,
        S_WAIT0,
        S_REQ1,
        S_WAIT1,
        S_LANE_EN,
        S_PORT_EN,
        S_HOLD,
        S_WAIT_RDY,
        S_TRAIN,
        S_WAIT_LINK,
        S_SETTLE
    } seq_state_t;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_ACK_TO  = 2'd1,
        ST_RDY_TO  = 2'd2,
        ST_LINK_TO = 2'd3
    } seq_status_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbu_usec_tick.sv
// Free-running microsecond tick: divides the core clock by CYC_PER_US.
// Assumes: CYC_PER_US >= 1; the tick is a one-cycle pulse.
module pbu_usec_tick #(
    parameter int unsigned CYC_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick
);
    generate
        if (CYC_PER_US == 1) begin : g_pass
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign us_tick = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(CYC_PER_US);
            localparam logic [CW-1:0] TOP = CW'(CYC_PER_US - 1);
            logic [CW-1:0] cnt_q;

            // Wrap the divider counter every CYC_PER_US cycles.
            always_ff @(posedge clk) begin
                if (!rst_n)             cnt_q <= '0;
                else if (cnt_q == TOP)  cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign us_tick = (cnt_q == TOP);
        end
    endgenerate
endmodule

// File: rtl/pbu_span_timer.sv
// Microsecond span timer: after a load of len_us, pulses expire once the
// len_us-th following tick has been counted.
// Assumes: len_us >= 1; a load restarts the span; a tick in the load cycle is ignored.
module pbu_span_timer #(
    parameter int unsigned TW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick,
    input  logic          load,
    input  logic [TW-1:0] len_us,
    output logic          expire
);
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] len_q;
    logic          run_q;

    // Count ticks while running and raise a one-cycle expiry at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            run_q  <= 1'b0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                cnt_q <= '0;
                len_q <= len_us;
                run_q <= 1'b1;
            end else if (run_q && us_tick) begin
                if (cnt_q + 1'b1 >= len_q) begin
                    run_q  <= 1'b0;
                    expire <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pbu_poll_ctr.sv
// Saturating poll counter: counts failed samples and flags the final one
// allowed by the limit presented on the same cycle.
// Assumes: limit >= 1.
module pbu_poll_ctr #(
    parameter int unsigned PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [PW-1:0] limit,
    output logic          last
);
    logic [PW-1:0] cnt_q;

    // Clear on a new wait; step on each failed sample, never wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clr)                   cnt_q <= '0;
        else if (inc && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
    end

    assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/pbu_seq_fsm.sv
// Bring-up state machine: orders clock handshakes, reset hold, ready and
// link polling, and records the outcome. All outputs are registered.
// Assumes: timer and poll counter are the companions wired in the top module;
// inputs are synchronous to clk.
module pbu_seq_fsm
    import pbu_pkg::*;
#(
    parameter int unsigned TW             = 17,
    parameter int unsigned PW             = 12,
    parameter int unsigned POLL_US        = 100,
    parameter int unsigned ACK_POLLS      = 500,
    parameter int unsigned READY_POLLS    = 2500,
    parameter int unsigned LINK_POLLS     = 1000,
    parameter int unsigned PERST_SHORT_US = 100,
    parameter int unsigned PERST_LONG_US  = 100000,
    parameter int unsigned SETTLE_US      = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          pwr_opt_i,
    input  logic [1:0]    refclk_ack_i,
    input  logic          port_ready_i,
    input  logic          link_up_i,
    input  logic          tmr_expire,
    input  logic          pc_last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_len,
    output logic          pc_clr,
    output logic          pc_inc,
    output logic [PW-1:0] pc_lim,
    output logic          app_clk_en_o,
    output logic          perst_n_o,
    output logic          pwr_en_o,
    output logic [1:0]    refclk_req_o,
    output logic [1:0]    refclk_lane_en_o,
    output logic          port_refclk_en_o,
    output logic          gate_dis_clr_o,
    output logic          ltssm_start_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          ok_o,
    output logic [1:0]    status_o
);
    localparam logic [TW-1:0] POLL_LEN  = TW'(POLL_US);
    localparam logic [TW-1:0] SHORT_LEN = TW'(PERST_SHORT_US);
    localparam logic [TW-1:0] LONG_LEN  = TW'(PERST_LONG_US);
    localparam logic [TW-1:0] SETL_LEN  = TW'(SETTLE_US);
    localparam logic [PW-1:0] ACK_LIM   = PW'(ACK_POLLS);
    localparam logic [PW-1:0] RDY_LIM   = PW'(READY_POLLS);
    localparam logic [PW-1:0] LNK_LIM   = PW'(LINK_POLLS);

    seq_state_t  st_q, st_d;
    seq_status_t stat_q, stat_d;
    logic        app_q, app_d, perst_q, perst_d, pwr_q, pwr_d;
    logic [1:0]  req_q, req_d, lane_q, lane_d;
    logic        port_q, port_d, gate_q, gate_d, ltssm_q, ltssm_d;
    logic        done_q, done_d, ok_q, ok_d;
    logic        miss_q, miss_d, used_q, used_d, fresh_q, fresh_d;
    logic        poll_now;

    // Poll instants: the first cycle of a wait and each interval expiry.
    assign poll_now = fresh_q | tmr_expire;

    // Next-state, output updates and companion-block controls.
    always_comb begin
        st_d     = st_q;
        stat_d   = stat_q;
        app_d    = app_q;
        perst_d  = perst_q;
        pwr_d    = pwr_q;
        req_d    = req_q;
        lane_d   = lane_q;
        port_d   = port_q;
        gate_d   = gate_q;
        ltssm_d  = 1'b0;
        done_d   = done_q;
        ok_d     = ok_q;
        miss_d   = miss_q;
        used_d   = used_q;
        fresh_d  = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = POLL_LEN;
        pc_clr   = 1'b0;
        pc_inc   = 1'b0;
        pc_lim   = ACK_LIM;

        case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    if (link_up_i) begin
                        done_d = 1'b1;
                        ok_d   = 1'b1;
                        stat_d = ST_OK;
                    end else begin
                        done_d = 1'b0;
                        ok_d   = 1'b0;
                        stat_d = ST_OK;
                        miss_d = 1'b0;
                        req_d  = 2'b00;
                        lane_d = 2'b00;
                        port_d = 1'b0;
                        gate_d = 1'b0;
                        st_d   = S_PREP;
                    end
                end
            end
            S_PREP: begin
                app_d   = 1'b1;
                perst_d = 1'b0;
                pwr_d   = pwr_opt_i;
                used_d  = pwr_opt_i;
                st_d    = S_REQ0;
            end
            S_REQ0: begin
                req_d[0] = 1'b1;
                pc_clr   = 1'b1;
                fresh_d  = 1'b1;
                st_d     = S_WAIT0;
            end
            S_WAIT0: begin
                pc_lim = ACK_LIM;
                if (poll_now) begin
                    if (refclk_ack_i[0]) begin
                        st_d = S_REQ1;
                    end else if (pc_last) begin
                        miss_d = 1'b1;
                        st_d   = S_REQ1;
                    end else begin
                        pc_inc   = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_REQ1: begin
                req_d[1] = 1'b1;
                pc_clr   = 1'b1;
                fresh_d  = 1'b1;
                st_d     = S_WAIT1;
            end
            S_WAIT1: begin
                pc_lim = ACK_LIM;
                if (poll_now) begin
                    if (refclk_ack_i[1]) begin
                        st_d = S_LANE_EN;
                    end else if (pc_last) begin
                        miss_d = 1'b1;
                        st_d   = S_LANE_EN;
                    end else begin
                        pc_inc   = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_LANE_EN: begin
                lane_d = 2'b11;
                st_d   = S_PORT_EN;
            end
            S_PORT_EN: begin
                port_d   = 1'b1;
                tmr_load = 1'b1;
                tmr_len  = used_q ? LONG_LEN : SHORT_LEN;
                st_d     = S_HOLD;
            end
            S_HOLD: begin
                if (tmr_expire) begin
                    perst_d = 1'b1;
                    pc_clr  = 1'b1;
                    fresh_d = 1'b1;
                    st_d    = S_WAIT_RDY;
                end
            end
            S_WAIT_RDY: begin
                pc_lim = RDY_LIM;
                if (poll_now) begin
                    if (port_ready_i) begin
                        st_d = S_TRAIN;
                    end else if (pc_last) begin
                        done_d = 1'b1;
                        ok_d   = 1'b0;
                        stat_d = ST_RDY_TO;
                        st_d   = S_IDLE;
                    end else begin
                        pc_inc   = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_TRAIN: begin
                gate_d  = 1'b1;
                ltssm_d = 1'b1;
                pc_clr  = 1'b1;
                fresh_d = 1'b1;
                st_d    = S_WAIT_LINK;
            end
            S_WAIT_LINK: begin
                pc_lim = LNK_LIM;
                if (poll_now) begin
                    if (link_up_i) begin
                        tmr_load = 1'b1;
                        tmr_len  = SETL_LEN;
                        st_d     = S_SETTLE;
                    end else if (pc_last) begin
                        done_d = 1'b1;
                        ok_d   = 1'b0;
                        stat_d = ST_LINK_TO;
                        st_d   = S_IDLE;
                    end else begin
                        pc_inc   = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_SETTLE: begin
                if (tmr_expire) begin
                    done_d = 1'b1;
                    ok_d   = 1'b1;
                    stat_d = miss_q ? ST_ACK_TO : ST_OK;
                    st_d   = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State and registered outputs; reset leaves PERST# asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            stat_q  <= ST_OK;
            app_q   <= 1'b0;
            perst_q <= 1'b0;
            pwr_q   <= 1'b0;
            req_q   <= 2'b00;
            lane_q  <= 2'b00;
            port_q  <= 1'b0;
            gate_q  <= 1'b0;
            ltssm_q <= 1'b0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            miss_q  <= 1'b0;
            used_q  <= 1'b0;
            fresh_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            stat_q  <= stat_d;
            app_q   <= app_d;
            perst_q <= perst_d;
            pwr_q   <= pwr_d;
            req_q   <= req_d;
            lane_q  <= lane_d;
            port_q  <= port_d;
            gate_q  <= gate_d;
            ltssm_q <= ltssm_d;
            done_q  <= done_d;
            ok_q    <= ok_d;
            miss_q  <= miss_d;
            used_q  <= used_d;
            fresh_q <= fresh_d;
        end
    end

    assign app_clk_en_o     = app_q;
    assign perst_n_o        = perst_q;
    assign pwr_en_o         = pwr_q;
    assign refclk_req_o     = req_q;
    assign refclk_lane_en_o = lane_q;
    assign port_refclk_en_o = port_q;
    assign gate_dis_clr_o   = gate_q;
    assign ltssm_start_o    = ltssm_q;
    assign busy_o           = (st_q != S_IDLE);
    assign done_o           = done_q;
    assign ok_o             = ok_q;
    assign status_o         = stat_q;
endmodule

// File: rtl/pcie_port_bringup.sv
// Top of the root-port bring-up sequencer: tick divider, span timer,
// poll counter and the sequencing state machine.
// Assumes: all timing parameters >= 1; inputs synchronous to clk.
module pcie_port_bringup
    import pbu_pkg::*;
#(
    parameter int unsigned CYC_PER_US     = 200,
    parameter int unsigned POLL_US        = 100,
    parameter int unsigned ACK_POLLS      = 500,
    parameter int unsigned READY_POLLS    = 2500,
    parameter int unsigned LINK_POLLS     = 1000,
    parameter int unsigned PERST_SHORT_US = 100,
    parameter int unsigned PERST_LONG_US  = 100000,
    parameter int unsigned SETTLE_US      = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pwr_opt_i,
    input  logic [1:0] refclk_ack_i,
    input  logic       port_ready_i,
    input  logic       link_up_i,
    output logic       app_clk_en_o,
    output logic       perst_n_o,
    output logic       pwr_en_o,
    output logic [1:0] refclk_req_o,
    output logic [1:0] refclk_lane_en_o,
    output logic       port_refclk_en_o,
    output logic       gate_dis_clr_o,
    output logic       ltssm_start_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       ok_o,
    output logic [1:0] status_o
);
    localparam int unsigned MAX_US = max2(max2(POLL_US, PERST_SHORT_US),
                                          max2(PERST_LONG_US, SETTLE_US));
    localparam int unsigned MAX_PL = max2(ACK_POLLS, max2(READY_POLLS, LINK_POLLS));
    localparam int unsigned TW     = $clog2(MAX_US + 1);
    localparam int unsigned PW     = $clog2(MAX_PL + 1);

    logic          us_tick;
    logic          tmr_load, tmr_expire;
    logic [TW-1:0] tmr_len;
    logic          pc_clr, pc_inc, pc_last;
    logic [PW-1:0] pc_lim;

    pbu_usec_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick)
    );

    pbu_span_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .load    (tmr_load),
        .len_us  (tmr_len),
        .expire  (tmr_expire)
    );

    pbu_poll_ctr #(.PW(PW)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pc_clr),
        .inc   (pc_inc),
        .limit (pc_lim),
        .last  (pc_last)
    );

    pbu_seq_fsm #(
        .TW             (TW),
        .PW             (PW),
        .POLL_US        (POLL_US),
        .ACK_POLLS      (ACK_POLLS),
        .READY_POLLS    (READY_POLLS),
        .LINK_POLLS     (LINK_POLLS),
        .PERST_SHORT_US (PERST_SHORT_US),
        .PERST_LONG_US  (PERST_LONG_US),
        .SETTLE_US      (SETTLE_US)
    ) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .pwr_opt_i        (pwr_opt_i),
        .refclk_ack_i     (refclk_ack_i),
        .port_ready_i     (port_ready_i),
        .link_up_i        (link_up_i),
        .tmr_expire       (tmr_expire),
        .pc_last          (pc_last),
        .tmr_load         (tmr_load),
        .tmr_len          (tmr_len),
        .pc_clr           (pc_clr),
        .pc_inc           (pc_inc),
        .pc_lim           (pc_lim),
        .app_clk_en_o     (app_clk_en_o),
        .perst_n_o        (perst_n_o),
        .pwr_en_o         (pwr_en_o),
        .refclk_req_o     (refclk_req_o),
        .refclk_lane_en_o (refclk_lane_en_o),
        .port_refclk_en_o (port_refclk_en_o),
        .gate_dis_clr_o   (gate_dis_clr_o),
        .ltssm_start_o    (ltssm_start_o),
        .busy_o           (busy_o),
        .done_o           (done_o),
        .ok_o             (ok_o),
        .status_o         (status_o)
    );
endmodule

// File: rtl/pbu_checker.sv
// Protocol checker for the bring-up sequencer, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module pbu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       perst_n_o,
    input logic       pwr_en_o,
    input logic [1:0] refclk_req_o,
    input logic [1:0] refclk_lane_en_o,
    input logic       port_refclk_en_o,
    input logic       gate_dis_clr_o,
    input logic       ltssm_start_o,
    input logic       done_o,
    input logic       ok_o,
    input logic [1:0] status_o
);
    // R3
    pwr_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_o) |-> !perst_n_o);

    // R4
    req_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refclk_req_o[1]) |-> refclk_req_o[0]);

    // R5
    lane_before_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_refclk_en_o) |-> $past(refclk_lane_en_o) == 2'b11);

    // R6
    perst_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> port_refclk_en_o && (refclk_lane_en_o == 2'b11));

    // R8
    ltssm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_start_o |=> !ltssm_start_o);

    // R8
    ltssm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_start_o |-> gate_dis_clr_o && perst_n_o);

    // R12
    good_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> !status_o[1]);

    // R12
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> status_o[1]);
endmodule

bind pcie_port_bringup pbu_checker u_pbu_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .perst_n_o        (perst_n_o),
    .pwr_en_o         (pwr_en_o),
    .refclk_req_o     (refclk_req_o),
    .refclk_lane_en_o (refclk_lane_en_o),
    .port_refclk_en_o (port_refclk_en_o),
    .gate_dis_clr_o   (gate_dis_clr_o),
    .ltssm_start_o    (ltssm_start_o),
    .done_o           (done_o),
    .ok_o             (ok_o),
    .status_o         (status_o)
);

// File: tb/tb_pcie_port_bringup.sv
`timescale 1ns/1ps
module tb_pcie_port_bringup;
    localparam int C     = 2;
    localparam int POLL  = 2;
    localparam int ACKN  = 3;
    localparam int RDYN  = 4;
    localparam int LNKN  = 3;
    localparam int SHORT = 5;
    localparam int LONG  = 20;
    localparam int SETL  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pwr_opt_i = 1'b0;
    logic [1:0] refclk_ack_i;
    logic       port_ready_i, link_up_i;
    logic       app_clk_en_o, perst_n_o, pwr_en_o, port_refclk_en_o;
    logic       gate_dis_clr_o, ltssm_start_o, busy_o, done_o, ok_o;
    logic [1:0] refclk_req_o, refclk_lane_en_o, status_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // stub controls, written only by the stimulus process
    int ack_dly [2] = '{0, 0};
    int rdy_dly = 0;
    int lnk_dly = 0;
    bit lnk_preset = 1'b0;

    always #2.5 clk = ~clk;

    pcie_port_bringup #(
        .CYC_PER_US(C), .POLL_US(POLL), .ACK_POLLS(ACKN), .READY_POLLS(RDYN),
        .LINK_POLLS(LNKN), .PERST_SHORT_US(SHORT), .PERST_LONG_US(LONG),
        .SETTLE_US(SETL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_opt_i(pwr_opt_i),
        .refclk_ack_i(refclk_ack_i), .port_ready_i(port_ready_i),
        .link_up_i(link_up_i), .app_clk_en_o(app_clk_en_o), .perst_n_o(perst_n_o),
        .pwr_en_o(pwr_en_o), .refclk_req_o(refclk_req_o),
        .refclk_lane_en_o(refclk_lane_en_o), .port_refclk_en_o(port_refclk_en_o),
        .gate_dis_clr_o(gate_dis_clr_o), .ltssm_start_o(ltssm_start_o),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .status_o(status_o)
    );

    // PHY, port and link stubs, updated away from the active edge
    int ack_cnt [2];
    int rdy_cnt, lnk_cnt;
    bit lnk_armed;
    initial begin
        refclk_ack_i = 2'b00; port_ready_i = 1'b0; link_up_i = 1'b0;
        ack_cnt = '{0, 0}; rdy_cnt = 0; lnk_cnt = 0; lnk_armed = 1'b0;
    end
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n || !refclk_req_o[i]) begin
                ack_cnt[i] = 0; refclk_ack_i[i] = 1'b0;
            end else if (ack_dly[i] >= 0 && ack_cnt[i] >= ack_dly[i]) begin
                refclk_ack_i[i] = 1'b1;
            end else begin
                ack_cnt[i] = ack_cnt[i] + 1;
            end
        end
        if (!rst_n || !perst_n_o) begin
            rdy_cnt = 0; port_ready_i = 1'b0;
        end else if (rdy_dly >= 0 && rdy_cnt >= rdy_dly) port_ready_i = 1'b1;
        else rdy_cnt = rdy_cnt + 1;
        if (!rst_n) begin
            lnk_armed = 1'b0; lnk_cnt = 0; link_up_i = lnk_preset;
        end else if (lnk_preset) begin
            link_up_i = 1'b1;
        end else begin
            if (ltssm_start_o) lnk_armed = 1'b1;
            if (lnk_armed) begin
                if (lnk_dly >= 0 && lnk_cnt >= lnk_dly) link_up_i = 1'b1;
                else lnk_cnt = lnk_cnt + 1;
            end
        end
    end

    // edge monitor: cycle stamps of output events
    int t_req0, t_req1, t_lane, t_port, t_perst, t_ltssm, t_link, t_done;
    int n_ltssm, n_lane_fall, n_split, n_done;
    logic [1:0] p_req, p_lane;
    logic p_port, p_perst, p_link, p_done;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            t_req0 = -1; t_req1 = -1; t_lane = -1; t_port = -1; t_perst = -1;
            t_ltssm = -1; t_link = -1; t_done = -1;
            n_ltssm = 0; n_lane_fall = 0; n_split = 0; n_done = 0;
        end else begin
            if (refclk_req_o[0] && !p_req[0]) t_req0 = cyc;
            if (refclk_req_o[1] && !p_req[1]) t_req1 = cyc;
            if (refclk_lane_en_o == 2'b11 && p_lane != 2'b11) t_lane = cyc;
            if (refclk_lane_en_o == 2'b01 || refclk_lane_en_o == 2'b10) n_split++;
            if (refclk_lane_en_o != 2'b11 && p_lane == 2'b11) n_lane_fall++;
            if (port_refclk_en_o && !p_port) t_port = cyc;
            if (perst_n_o && !p_perst) t_perst = cyc;
            if (ltssm_start_o) begin n_ltssm++; t_ltssm = cyc; end
            if (link_up_i && !p_link) t_link = cyc;
            if (done_o && !p_done) begin t_done = cyc; n_done++; end
        end
        p_req = refclk_req_o; p_lane = refclk_lane_en_o; p_port = port_refclk_en_o;
        p_perst = perst_n_o; p_link = link_up_i; p_done = done_o;
    end

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_case(input bit pwr, input int a0, input int a1,
                            input int rd, input int lk, input bit restart);
        int exp_stat, gap, lim;
        bit exp_ok;
        ack_dly[0] = a0; ack_dly[1] = a1; rdy_dly = rd; lnk_dly = lk;
        lnk_preset = 1'b0; pwr_opt_i = pwr;
        do_reset();
        pulse_start();
        if (restart) begin
            repeat (8) @(negedge clk);
            pulse_start();
        end
        for (int k = 0; k < 3000 && !done_o; k++) @(negedge clk);
        @(negedge clk);
        exp_stat = (rd < 0) ? 2 : (lk < 0) ? 3 : (a0 < 0 || a1 < 0) ? 1 : 0;
        exp_ok = (rd >= 0) && (lk >= 0);
        chk(done_o && status_o == 2'(exp_stat), "R12 status", status_o, exp_stat);
        chk(ok_o == exp_ok, "R12 ok", ok_o, exp_ok);
        chk(pwr_en_o == pwr && app_clk_en_o, "R3 power/appclk", pwr_en_o, pwr);
        chk(t_req1 > t_req0 && t_req0 > 0, "R4 request order", t_req1, t_req0 + 1);
        if (a0 < 0) chk(t_req1 - t_req0 >= (ACKN - 1) * POLL * C, "R4 ack0 timeout span",
                        t_req1 - t_req0, (ACKN - 1) * POLL * C);
        chk(n_split == 0 && refclk_lane_en_o == 2'b11, "R5 lane pair", n_split, 0);
        chk(t_port == t_lane + 1, "R5 port after lane", t_port, t_lane + 1);
        lim = pwr ? LONG : SHORT;
        gap = t_perst - t_port;
        chk(gap >= (lim - 1) * C + 1 && gap <= lim * C + 2, "R6 PERST hold", gap, lim * C);
        if (rd < 0) begin
            chk(n_ltssm == 0 && !gate_dis_clr_o, "R7 no training", n_ltssm, 0);
            chk(t_done - t_perst >= (RDYN - 1) * POLL * C, "R7 ready timeout span",
                t_done - t_perst, (RDYN - 1) * POLL * C);
        end else begin
            chk(n_ltssm == 1 && gate_dis_clr_o, "R8 single training pulse", n_ltssm, 1);
        end
        if (rd >= 0 && lk < 0)
            chk(t_done - t_ltssm >= (LNKN - 1) * POLL * C, "R9 link timeout span",
                t_done - t_ltssm, (LNKN - 1) * POLL * C);
        if (exp_ok) begin
            gap = t_done - t_link;
            chk(gap >= (SETL - 1) * C && gap <= SETL * C + POLL * C + 4, "R10 settle",
                gap, SETL * C);
        end
        if (restart)
            chk(n_lane_fall == 0 && n_done == 1 && n_ltssm == (rd >= 0 ? 1 : 0),
                "R11 busy start ignored", n_lane_fall, 0);
    endtask

    initial begin
        int dl [3];
        dl = '{0, 3, -1};
        do_reset();
        // R1 reset state
        chk(!perst_n_o && !app_clk_en_o && !pwr_en_o && refclk_req_o == 0 &&
            refclk_lane_en_o == 0 && !port_refclk_en_o && !gate_dis_clr_o &&
            !ltssm_start_o && !busy_o && !done_o && !ok_o && status_o == 0,
            "R1 reset outputs", {perst_n_o, busy_o, done_o}, 0);

        // R2 link already up
        lnk_preset = 1'b1;
        do_reset();
        pulse_start();
        chk(done_o && ok_o && status_o == 0 && !busy_o, "R2 skip result",
            {done_o, ok_o, status_o}, 4'b1100);
        chk(!app_clk_en_o && !perst_n_o && refclk_req_o == 0 && !pwr_en_o,
            "R2 outputs untouched", {app_clk_en_o, perst_n_o, refclk_req_o}, 0);

        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    for (int r = 0; r < 2; r++)
                        for (int l = 0; l < 2; l++)
                            run_case(p[0], dl[i], dl[j], r ? -1 : 2, l ? -1 : 2, 1'b0);

        run_case(1'b0, 0, 3, 2, 2, 1'b1);
        run_case(1'b1, -1, 0, -1, 2, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule